// File: doc/BRIEF.md
# Serial Port Register File

This block is the byte-wide register face of a PC-style serial port. A bus master reaches it through eight byte offsets. Behind them sit the interrupt enable, interrupt identification, line control, line status, modem control, modem status and scratch registers, a 16-bit baud divisor, and a receive byte queue. The block does no bit timing. A byte written to the data offset leaves at once on a transmit strobe. Received bytes arrive from the host side on a valid/ready push port and wait in the queue until the bus reads them.

Loopback mode turns the transmit path back into the receive queue and shuts out the host input. Several reads change state. Reading the data offset pops the queue. Reading the identification register returns its value and then clears it. A single request line gives one pulse for each cycle in which an interrupt event happens.

Receive port rules: a byte is accepted in every cycle where `rx_valid` and `rx_ready` are both high. Outside loopback, `rx_ready` falls when the queue is full, and a byte offered then stays with the producer. In loopback, `rx_ready` stays high and every offered byte is thrown away. The transmit strobe has no back-pressure, so the consumer must take every `tx_valid` pulse.

Top module: `serial_regport`

## Requirements
- R1: After reset the registers read as follows. Offset 1 (interrupt enable) reads 0x00 and offset 2 (identification) reads 0xC1. Offset 3 (line control) reads 0x03, offset 4 (modem control) 0x08, offset 5 (line status) 0x60, offset 6 (modem status) 0xB0 and offset 7 (scratch) 0x00. The divisor is 12 and the queue is empty. `tx_valid`, `irq_pulse` and `bus_rdata` are 0, and `rx_ready` is 1.
- R2: A read in cycle t puts its data on `bus_rdata` after the edge that ends cycle t, and `bus_rdata` holds that value until the next read. Offsets 3, 4 and 7 are plain read/write registers. Writes to offsets 2, 5 and 6 have no effect. Offset 6 always reads 0xB0.
- R3: While line-control bit 7 is 1, offset 0 reads and writes the low byte of the divisor and offset 1 the high byte. The queue, the data path and the interrupt enable are left untouched.
- R4: A write to offset 1 (bit 7 clear) stores only bits 3:0. Bits 7:4 read back as 0. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R5: A data write with modem-control bit 4 clear raises `tx_valid` for one cycle, with the byte on `tx_data`, in the cycle after the write. If enable bit 1 is set, identification bit 0 clears and bit 1 sets.
- R6: While modem-control bit 4 is set, a data write pushes the byte into the queue only if the queue holds fewer than 64 bytes, and nothing is transmitted. Host bytes are accepted and discarded.
- R7: Outside loopback, `rx_ready` is 0 exactly when the queue holds 64 bytes. Each accepted host byte enters the queue.
- R8: A data read returns the oldest queued byte and removes it, or returns 0 when the queue is empty. Line-status bit 0 is 1 exactly when the queue is not empty.
- R9: A data read clears identification bit 2. If that leaves all identification bits 0, the register becomes 0x01.
- R10: An identification read returns the value with bits 7:6 forced to 1, then the register returns to 0x01. An event in the same cycle is applied after that clear and is kept.
- R11: Each byte entering the queue with enable bit 0 set clears identification bit 0 and sets bit 2. `irq_pulse` is high for exactly one cycle after any cycle with at least one transmit or receive interrupt event. Two events in the same cycle give a single pulse.
- R12: A host push and a data read in the same cycle both take effect. The queue count and line-status bit 0 reflect both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Host byte offered |
| rx_ready | output | 1 | Host byte can be taken |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Transmitted byte strobe |
| tx_data | output | 8 | Transmitted byte |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Two functions can fall in the same cycle: a host push, and a bus read that consumes state. The read is either a data pop or an identification read. Directed cases drive both in one cycle, once with one byte queued and once with the queue empty. They then read the line status and the identification register to check that neither action was lost. A bench model applies clear-then-set ordering and pop-before-push, and judges every cycle of a long run of seeded random traffic. In that run, host offers, data reads, identification reads and data writes overlap freely.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IID   = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

  localparam logic [7:0]  LCTL_RST     = 8'h03;
  localparam logic [7:0]  MCTL_RST     = 8'h08;
  localparam logic [7:0]  MSTAT_VAL    = 8'hB0;
  localparam logic [7:0]  LSTAT_FIXED  = 8'h60;
  localparam logic [7:0]  IID_RD_FORCE = 8'hC0;
  localparam logic [15:0] DIV_RST      = 16'd12;

  localparam logic [2:0] IID_NONE = 3'b001;
  localparam logic [2:0] IID_TXE  = 3'b010;
  localparam logic [2:0] IID_RXD  = 3'b100;

  localparam int LCTL_DIVACC_BIT = 7;
  localparam int MCTL_LOOP_BIT   = 4;
  localparam int IEN_RX_BIT      = 0;
  localparam int IEN_TX_BIT      = 1;
endpackage

// File: rtl/serport_rxq.sv
module serport_rxq #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_PUSH_POP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt)); // R12
endmodule

// File: rtl/serport_iid.sv
module serport_iid
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_clr,
  input  logic       rx_ack,
  input  logic       tx_evt,
  input  logic       rx_evt,
  output logic [2:0] iid
);
  logic [2:0] iid_q, nxt;

  always_comb begin
    nxt = rd_clr ? IID_NONE : iid_q;
    if (rx_ack) begin
      nxt = nxt & ~IID_RXD;
      if (nxt == 3'b000) nxt = IID_NONE;
    end
    if (tx_evt) nxt = (nxt & ~IID_NONE) | IID_TXE;
    if (rx_evt) nxt = (nxt & ~IID_NONE) | IID_RXD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iid_q <= IID_NONE;
    else        iid_q <= nxt;
  end

  assign iid = iid_q;

  AST_IID_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    iid_q != 3'b000); // R9
  AST_TX_EVT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> (iid_q[1] && !iid_q[0])); // R5
  AST_RX_EVT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> (iid_q[2] && !iid_q[0])); // R11
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import serport_pkg::*;
#(
  parameter int RXQ_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq_pulse
);
  logic [3:0]  ien_q;
  logic [7:0]  lctl_q, mctl_q, scr_q;
  logic [15:0] div_q;
  logic [2:0]  iid;
  logic [7:0]  q_head, rd_mux, lstat;
  logic        q_full, q_empty;

  logic divacc, loopb, data_sel, wr_data, rd_data;
  logic tx_evt, lp_push, host_push, q_push, q_pop, tx_irq, rx_irq;

  assign divacc    = lctl_q[LCTL_DIVACC_BIT];
  assign loopb     = mctl_q[MCTL_LOOP_BIT];
  assign data_sel  = (bus_addr == OFS_DATA) && !divacc;
  assign wr_data   = bus_wr && data_sel;
  assign rd_data   = bus_rd && data_sel;
  assign tx_evt    = wr_data && !loopb;
  assign lp_push   = wr_data && loopb && !q_full;
  assign host_push = rx_valid && !loopb && !q_full;
  assign q_push    = lp_push || host_push;
  assign q_pop     = rd_data && !q_empty;
  assign rx_ready  = loopb || !q_full;
  assign tx_irq    = tx_evt && ien_q[IEN_TX_BIT];
  assign rx_irq    = q_push && ien_q[IEN_RX_BIT];
  assign lstat     = LSTAT_FIXED | {7'b0, !q_empty};

  serport_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (loopb ? bus_wdata : rx_data),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  serport_iid u_iid (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (bus_rd && (bus_addr == OFS_IID)),
    .rx_ack (rd_data),
    .tx_evt (tx_irq),
    .rx_evt (rx_irq),
    .iid    (iid)
  );

  always_comb begin
    rd_mux = 8'h00;
    case (bus_addr)
      OFS_DATA:  rd_mux = divacc ? div_q[7:0] : (q_empty ? 8'h00 : q_head);
      OFS_IEN:   rd_mux = divacc ? div_q[15:8] : {4'b0, ien_q};
      OFS_IID:   rd_mux = IID_RD_FORCE | {5'b0, iid};
      OFS_LCTL:  rd_mux = lctl_q;
      OFS_MCTL:  rd_mux = mctl_q;
      OFS_LSTAT: rd_mux = lstat;
      OFS_MSTAT: rd_mux = MSTAT_VAL;
      OFS_SCR:   rd_mux = scr_q;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      lctl_q    <= LCTL_RST;
      mctl_q    <= MCTL_RST;
      scr_q     <= '0;
      div_q     <= DIV_RST;
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      irq_pulse <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr) begin
        case (bus_addr)
          OFS_DATA: if (divacc) div_q[7:0] <= bus_wdata;
          OFS_IEN: begin
            if (divacc) div_q[15:8] <= bus_wdata;
            else        ien_q <= bus_wdata[3:0];
          end
          OFS_LCTL: lctl_q <= bus_wdata;
          OFS_MCTL: mctl_q <= bus_wdata;
          OFS_SCR:  scr_q  <= bus_wdata;
          default: ;
        endcase
      end
      tx_valid <= tx_evt;
      if (tx_evt) tx_data <= bus_wdata;
      irq_pulse <= tx_irq || rx_irq;
    end
  end

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !iid[0]); // R11
  AST_TX_NOT_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !$past(loopb)); // R6
  AST_LSTAT_TRACKS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> lstat[0]); // R8
endmodule

// File: tb/serial_regport_tb_top.sv
module serial_regport_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_rd, bus_wr, rx_valid;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, rx_data, bus_rdata, tx_data;
  logic       rx_ready, tx_valid, irq_pulse;

  always #4 clk = ~clk;

  serial_regport #(.RXQ_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_pulse(irq_pulse)
  );

  int n_chk = 0, n_fail = 0;

  logic [3:0]  m_ier;
  logic [2:0]  m_iid;
  logic [7:0]  m_lcr, m_mcr, m_scr;
  logic [15:0] m_div;
  logic [7:0]  m_q[$];
  logic [7:0]  e_rdata, e_txd;
  logic        e_txv, e_irq;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ier = 4'h0; m_iid = 3'b001; m_lcr = 8'h03; m_mcr = 8'h08;
    m_scr = 8'h00; m_div = 16'd12; m_q.delete();
    e_rdata = 8'h00; e_txd = 8'h00; e_txv = 1'b0; e_irq = 1'b0;
  endtask

  function automatic string rtag(bit rd, logic [2:0] a, bit dl);
    if (!rd) return "R2";
    if (a <= 3'd1 && dl) return "R3";
    if (a == 3'd0) return "R8";
    if (a == 3'd1) return "R4";
    if (a == 3'd2) return "R10";
    return "R2";
  endfunction

  // One bus cycle: drive at a falling edge, update the model, check at the next falling edge.
  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] wd,
                     input bit rxv, input logic [7:0] rxd);
    int   sz   = m_q.size();
    bit   dl   = m_lcr[7];
    bit   lp   = m_mcr[4];
    bit   full = (m_q.size() >= DEPTH);
    bit   dsel = (a == 3'd0) && !m_lcr[7];
    bit   txe, lpp, hp, pop, trig;
    logic [7:0] rv;
    logic [2:0] ni;
    string tg;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; rx_valid = rxv; rx_data = rxd;
    #1;
    chk(rx_ready == (lp || !full), lp ? "R6" : "R7", "rx_ready", rx_ready, lp || !full);
    txe = wr && dsel && !lp;
    lpp = wr && dsel && lp && !full;
    hp  = rxv && !lp && !full;
    pop = rd && dsel && (sz > 0);
    trig = 1'b0;
    rv = e_rdata;
    if (rd) begin
      case (a)
        3'd0: rv = dl ? m_div[7:0] : ((sz > 0) ? m_q[0] : 8'h00);
        3'd1: rv = dl ? m_div[15:8] : {4'h0, m_ier};
        3'd2: rv = 8'hC0 | {5'b0, m_iid};
        3'd3: rv = m_lcr;
        3'd4: rv = m_mcr;
        3'd5: rv = (sz > 0) ? 8'h61 : 8'h60;
        3'd6: rv = 8'hB0;
        default: rv = m_scr;
      endcase
    end
    ni = (rd && a == 3'd2) ? 3'b001 : m_iid;
    if (rd && dsel) begin
      ni[2] = 1'b0;
      if (ni == 3'b000) ni = 3'b001;
    end
    if (txe && m_ier[1]) begin ni[0] = 1'b0; ni[1] = 1'b1; trig = 1'b1; end
    if ((lpp || hp) && m_ier[0]) begin ni[0] = 1'b0; ni[2] = 1'b1; trig = 1'b1; end
    if (pop) void'(m_q.pop_front());
    if (lpp) m_q.push_back(wd);
    if (hp)  m_q.push_back(rxd);
    if (wr) begin
      case (a)
        3'd0: if (dl) m_div[7:0] = wd;
        3'd1: if (dl) m_div[15:8] = wd; else m_ier = wd[3:0];
        3'd3: m_lcr = wd;
        3'd4: m_mcr = wd;
        3'd7: m_scr = wd;
        default: ;
      endcase
    end
    m_iid = ni;
    e_rdata = rv; e_txv = txe; e_irq = trig;
    if (txe) e_txd = wd;
    tg = rtag(rd, a, dl);
    @(negedge clk);
    chk(bus_rdata == e_rdata, tg, "bus_rdata", bus_rdata, e_rdata);
    chk(tx_valid == e_txv, "R5", "tx_valid", tx_valid, e_txv);
    if (e_txv) chk(tx_data == e_txd, "R5", "tx_data", tx_data, e_txd);
    chk(irq_pulse == e_irq, "R11", "irq_pulse", irq_pulse, e_irq);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0, 8'h00);
  endtask

  task automatic rdx(input logic [2:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00);
    chk(bus_rdata == exp, tag, "read value", bus_rdata, exp);
  endtask

  task automatic push(input logic [7:0] d);
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, d);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_valid == 0, "R1", "tx_valid", tx_valid, 0);
    chk(irq_pulse == 0, "R1", "irq_pulse", irq_pulse, 0);
    chk(bus_rdata == 0, "R1", "bus_rdata", bus_rdata, 0);
    chk(rx_ready == 1, "R1", "rx_ready", rx_ready, 1);
    rdx(3'd0, 8'h00, "R1"); rdx(3'd1, 8'h00, "R1"); rdx(3'd2, 8'hC1, "R1");
    rdx(3'd3, 8'h03, "R1"); rdx(3'd4, 8'h08, "R1"); rdx(3'd5, 8'h60, "R1");
    rdx(3'd6, 8'hB0, "R1"); rdx(3'd7, 8'h00, "R1");
    wr(3'd3, 8'h83);
    rdx(3'd0, 8'h0C, "R1"); rdx(3'd1, 8'h00, "R1");
    // R3 divisor access
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rdx(3'd0, 8'h12, "R3"); rdx(3'd1, 8'h34, "R3"); rdx(3'd3, 8'h83, "R3");
    wr(3'd3, 8'h03);
    rdx(3'd1, 8'h00, "R3"); rdx(3'd5, 8'h60, "R3");
    // R2 plain and read-only registers, held read data
    wr(3'd7, 8'hA5); wr(3'd2, 8'hFF); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    rdx(3'd7, 8'hA5, "R2"); idle();
    chk(bus_rdata == 8'hA5, "R2", "held rdata", bus_rdata, 8'hA5);
    rdx(3'd2, 8'hC1, "R2"); rdx(3'd5, 8'h60, "R2"); rdx(3'd6, 8'hB0, "R2");
    // R4 enable width
    wr(3'd1, 8'hFF); rdx(3'd1, 8'h0F, "R4");
    wr(3'd1, 8'h02);
    // R5 transmit
    wr(3'd0, 8'h41);
    chk(tx_valid == 1 && tx_data == 8'h41, "R5", "tx strobe", tx_data, 8'h41);
    chk(irq_pulse == 1, "R5", "irq after tx", irq_pulse, 1);
    idle();
    chk(tx_valid == 0, "R5", "tx one cycle", tx_valid, 0);
    rdx(3'd2, 8'hC2, "R10"); rdx(3'd2, 8'hC1, "R10");
    // R6 loopback
    wr(3'd1, 8'h01); wr(3'd4, 8'h18);
    push(8'h99);
    rdx(3'd5, 8'h60, "R6");
    wr(3'd0, 8'h61); wr(3'd0, 8'h62); wr(3'd0, 8'h63);
    rdx(3'd5, 8'h61, "R6"); rdx(3'd2, 8'hC4, "R11");
    rdx(3'd0, 8'h61, "R6"); rdx(3'd0, 8'h62, "R6"); rdx(3'd0, 8'h63, "R6");
    rdx(3'd5, 8'h60, "R8"); rdx(3'd0, 8'h00, "R8");
    wr(3'd1, 8'h00);
    for (int i = 0; i < DEPTH + 1; i++) wr(3'd0, 8'(i));
    for (int i = 0; i < DEPTH; i++) rdx(3'd0, 8'(i), "R6");
    rdx(3'd0, 8'h00, "R6");
    // R7 host push and back-pressure
    wr(3'd4, 8'h08);
    for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h80));
    chk(rx_ready == 0, "R7", "rx_ready full", rx_ready, 0);
    push(8'hEE);
    for (int i = 0; i < DEPTH; i++) rdx(3'd0, 8'(i + 8'h80), "R7");
    rdx(3'd0, 8'h00, "R7");
    // R9 data read clears receive bit
    wr(3'd1, 8'h03); rdx(3'd2, 8'hC1, "R9");
    wr(3'd0, 8'h20); push(8'h21);
    rdx(3'd0, 8'h21, "R9"); rdx(3'd2, 8'hC2, "R9");
    push(8'h22); rdx(3'd0, 8'h22, "R9"); rdx(3'd2, 8'hC1, "R9");
    // R12 push and pop in the same cycle
    wr(3'd1, 8'h01);
    push(8'h10);
    cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h20);
    chk(bus_rdata == 8'h10, "R12", "pop with push", bus_rdata, 8'h10);
    rdx(3'd5, 8'h61, "R12"); rdx(3'd0, 8'h20, "R12"); rdx(3'd5, 8'h60, "R12");
    cyc(1'b1, 1'b0, 3'd0, 8'h00, 1'b1, 8'h30);
    chk(bus_rdata == 8'h00, "R12", "empty pop with push", bus_rdata, 8'h00);
    rdx(3'd5, 8'h61, "R12"); rdx(3'd2, 8'hC4, "R12");
    cyc(1'b1, 1'b0, 3'd2, 8'h00, 1'b1, 8'h31);
    chk(bus_rdata == 8'hC1, "R10", "id read with push", bus_rdata, 8'hC1);
    rdx(3'd2, 8'hC4, "R10");
    rdx(3'd0, 8'h30, "R12"); rdx(3'd0, 8'h31, "R12");
    // R11 two events, one pulse
    wr(3'd1, 8'h03); rdx(3'd2, 8'hC1, "R11");
    cyc(1'b0, 1'b1, 3'd0, 8'h55, 1'b1, 8'h77);
    chk(irq_pulse == 1, "R11", "single pulse", irq_pulse, 1);
    idle();
    chk(irq_pulse == 0, "R11", "pulse ends", irq_pulse, 0);
    rdx(3'd2, 8'hC6, "R11"); rdx(3'd0, 8'h77, "R11");
    // seeded random traffic checked against the model
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom % 6;
      cyc(k == 1 || k == 3 || k == 5, k == 2 || k == 5, 3'($urandom),
          8'($urandom), ($urandom % 3) == 0, 8'($urandom));
    end
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule